// File: doc/BRIEF.md
# Port Expander Register Read Target

This block is the serial-bus target side of an 8-bit port expander. It watches the two-wire bus (clock and data, each seen as a plain input, with data pulled low through an open-drain enable). It recognises start, repeated start and stop. It acknowledges its own fixed 7-bit address. It keeps a command byte that picks one of four internal registers: the input port, the output port, polarity inversion and configuration. In the combined-format read, the controller writes the address and a command byte, issues a repeated start, then readdresses with the read flag. The target then shifts out the selected register, one byte for every acknowledge from the controller.

The command byte survives stop and start, and the register pointer never advances. Every byte of a long read therefore comes from the same register. A read that opens directly with the read address returns whatever register the last command byte chose. Data bytes that follow the command byte in a write transaction load the selected writable register. The output port and configuration registers appear on the block's outputs.

Top module: `i2cx_expander_target`

## Requirements
- R1: After reset the target releases data (`sda_oe_o` low), the output port and configuration registers hold 8'hFF, polarity inversion holds 8'h00, and the command byte is 8'h00, so a read with no command phase returns the input port.
- R2: The target acknowledges an address byte only when its upper seven bits equal `TARGET_ADDR`. On a mismatch it never pulls data low until the next start or stop.
- R3: For an address byte with the write flag (bit 0 = 0), and for the command byte that follows it, the target pulls data low during the ninth clock. It only begins pulling data low while the clock is low.
- R4: After address+write, command byte, repeated start and address+read (bit 0 = 1), the target shifts the selected register out most significant bit first. Each bit changes while the clock is low.
- R5: Only command bits [1:0] select the register: 0 = input port, 1 = output port, 2 = polarity inversion, 3 = configuration. Upper command bits are ignored.
- R6: Each controller acknowledge (data low in the ninth clock) yields another byte from the same register. There is no auto-increment.
- R7: The command byte persists across stop and start. A transaction that begins with address+read returns the register chosen by the most recent command byte.
- R8: The input port register reads as the pin value XOR the polarity register. It is captured at the rising clock edge of the acknowledge bit that precedes each byte, so pin changes during a byte appear only in the next byte.
- R9: When the controller does not acknowledge a read byte, the target releases data and ignores all clocks until the next start or stop.
- R10: A stop at any point returns the target to idle with data released, and the next transaction proceeds normally.
- R11: Data bytes after the command byte in a write transaction are acknowledged and load the selected register, with every byte going to the same register. Writes with selection 0 (the input port) change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| port_in_i | input | DATA_W | Input port pin values |
| out_port_o | output | DATA_W | Output port register contents |
| cfg_o | output | DATA_W | Configuration register contents |

## Verification
The assertions assume a well-behaved controller. The data line moves only while the clock is low, except for the start and stop edges. The controller never fights the target while the target holds data low. Each clock phase also lasts many system cycles, longer than the synchroniser delay. The directed bench drives every bit with ten system cycles per quarter bus period, and changes data only with the clock low. It releases data before each bit the target may drive. It issues stops only when the target has released the line, so every assumed condition holds throughout the stimulus.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } tgt_state_e;

   localparam int SEL_W = 2;
   typedef logic [SEL_W-1:0] reg_sel_t;

   localparam reg_sel_t SEL_INPUT  = 2'd0;
   localparam reg_sel_t SEL_OUTPUT = 2'd1;
   localparam reg_sel_t SEL_POLAR  = 2'd2;
   localparam reg_sel_t SEL_CONFIG = 2'd3;

endpackage

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   localparam int NLINES = 2;

   logic [NLINES-1:0] line_in;
   logic [NLINES-1:0] line_now;
   logic [NLINES-1:0] line_prev;

   assign line_in = {sda_i, scl_i};

   genvar g;
   generate
      for (g = 0; g < NLINES; g++) begin : g_line
         logic [STAGES:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-1:0], line_in[g]};
         end
         assign line_now[g]  = pipe[STAGES-1];
         assign line_prev[g] = pipe[STAGES];
      end
   endgenerate

   assign scl_s    = line_now[0];
   assign sda_s    = line_now[1];
   assign scl_rise = line_now[0] & ~line_prev[0];
   assign scl_fall = ~line_now[0] & line_prev[0];
   assign start_ev = line_now[0] & line_prev[0] & line_prev[1] & ~line_now[1];
   assign stop_ev  = line_now[0] & line_prev[0] & ~line_prev[1] & line_now[1];

endmodule

// File: rtl/i2cx_regfile.sv
module i2cx_regfile
   import i2cx_pkg::*;
#(
   parameter int               DATA_W  = 8,
   parameter logic [DATA_W-1:0] OUT_RST = '1,
   parameter logic [DATA_W-1:0] POL_RST = '0,
   parameter logic [DATA_W-1:0] CFG_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] port_in,
   input  logic              wr_en,
   input  reg_sel_t          sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] out_q,
   output logic [DATA_W-1:0] cfg_q
);

   localparam int NREG = 1 << SEL_W;

   logic [DATA_W-1:0] stor [1:NREG-1];
   logic [DATA_W-1:0] in_val;

   genvar g;
   generate
      for (g = 1; g < NREG; g++) begin : g_reg
         localparam logic [DATA_W-1:0] RV =
            (g == 1) ? OUT_RST : (g == 2) ? POL_RST : CFG_RST;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          stor[g] <= RV;
            else if (wr_en && sel == reg_sel_t'(g)) stor[g] <= wr_data;
         end
      end
   endgenerate

   assign in_val = port_in ^ stor[2];
   assign out_q  = stor[1];
   assign cfg_q  = stor[3];

   always_comb begin
      case (sel)
         SEL_OUTPUT: rd_data = stor[1];
         SEL_POLAR:  rd_data = stor[2];
         SEL_CONFIG: rd_data = stor[3];
         default:    rd_data = in_val;
      endcase
   end

   // R11: a write aimed at the input port leaves every stored register alone
   assert_inport_wr_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_INPUT) |=> ($stable(stor[1]) && $stable(stor[2]) && $stable(stor[3])));

endmodule

// File: rtl/i2cx_target_fsm.sv
module i2cx_target_fsm
   import i2cx_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [DATA_W-1:0] rd_data,
   output reg_sel_t          sel,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              sda_oe
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] tx;
   logic [DATA_W-1:0] cmd;
   logic              rw;

   assign sel = cmd[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         tx      <= '0;
         cmd     <= '0;
         rw      <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_ev) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise && cnt != FULL) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + ONE;
                  end else if (scl_fall && cnt == FULL) begin
                     if (state == ST_ADDR) begin
                        if (sh[DATA_W-1:1] == TARGET_ADDR) begin
                           rw     <= sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state  <= ST_IGNORE;
                        end
                     end else if (state == ST_CMD) begin
                        cmd    <= sh;
                        sda_oe <= 1'b1;
                        state  <= ST_CMD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_data <= sh;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_rise && rw) begin
                     tx <= rd_data;
                  end else if (scl_fall) begin
                     if (rw) begin
                        sda_oe <= ~tx[DATA_W-1];
                        cnt    <= ONE;
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~tx[DATA_W-2];
                        tx     <= {tx[DATA_W-2:0], 1'b0};
                        cnt    <= cnt + ONE;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (!sda_s) tx    <= rd_data;
                     else        state <= ST_IGNORE;
                  end else if (scl_fall) begin
                     sda_oe <= ~tx[DATA_W-1];
                     cnt    <= ONE;
                     state  <= ST_RDATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3, R4: the target only starts pulling data low while the clock is low
   assert_oe_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !$past(sda_oe)) |-> !scl_s);

   // R10: in idle the data line is released
   assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R9: after a NACK or an address mismatch the data line stays released
   assert_ignore_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);

   // R7: the command byte only changes when a command byte completes
   assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd) |-> ($past(state) == ST_CMD));

endmodule

// File: rtl/i2cx_expander_target.sv
module i2cx_expander_target
   import i2cx_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h38,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] OUT_RST     = '1,
   parameter logic [DATA_W-1:0] POL_RST     = '0,
   parameter logic [DATA_W-1:0] CFG_RST     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [DATA_W-1:0] port_in_i,
   output logic [DATA_W-1:0] out_port_o,
   output logic [DATA_W-1:0] cfg_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W + 1 != DATA_W) begin : g_chk_addr
         $error("address plus direction flag must fill one data byte");
      end
   endgenerate

   logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;
   reg_sel_t          sel;

   i2cx_bus_events #(.STAGES(SYNC_STAGES)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2cx_target_fsm #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .TARGET_ADDR (TARGET_ADDR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .rd_data  (rd_data),
      .sel      (sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sda_oe   (sda_oe_o)
   );

   i2cx_regfile #(
      .DATA_W  (DATA_W),
      .OUT_RST (OUT_RST),
      .POL_RST (POL_RST),
      .CFG_RST (CFG_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_in (port_in_i),
      .wr_en   (wr_en),
      .sel     (sel),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .out_q   (out_port_o),
      .cfg_q   (cfg_o)
   );

endmodule

// File: tb/tb_i2cx_expander_target.sv
module tb_i2cx_expander_target;

   localparam int        Q    = 10;
   localparam logic [6:0] ADDR = 7'h38;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic [7:0] port_in = 8'h00;
   logic       sda_oe;
   logic [7:0] out_port, cfg;
   logic       sda;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign sda = ~(m_low | sda_oe);

   i2cx_expander_target dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda),
      .sda_oe_o   (sda_oe),
      .port_in_i  (port_in),
      .out_port_o (out_port),
      .cfg_o      (cfg)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
   endtask

   task automatic send_bit(input logic b);
      m_low = ~b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
   endtask

   task automatic recv_bit(output logic b);
      m_low = 1'b0; qw(); scl = 1'b1; qw(); b = sda; qw(); scl = 1'b0; qw();
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack_n);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(ack_n);
   endtask

   task automatic read_byte(input logic last, input logic chg, input logic [7:0] newv,
                            output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         recv_bit(d[i]);
         if (chg && i == 4) port_in = newv;
      end
      send_bit(last);
   endtask

   task automatic set_cmd(input logic [7:0] c, input string req);
      logic a;
      bus_start();
      write_byte({ADDR, 1'b0}, a); check({req, " addr+W ack"}, {7'd0, a}, 8'h00);
      write_byte(c, a);            check({req, " cmd ack"}, {7'd0, a}, 8'h00);
   endtask

   task automatic read_direct(input logic [7:0] exp, input string req);
      logic a; logic [7:0] d;
      bus_start();
      write_byte({ADDR, 1'b1}, a); check({req, " addr+R ack"}, {7'd0, a}, 8'h00);
      read_byte(1'b1, 1'b0, 8'h00, d); check(req, d, exp);
      bus_stop();
   endtask

   task automatic combined_read(input logic [7:0] c, input logic [7:0] exp, input string req);
      logic a; logic [7:0] d;
      set_cmd(c, req);
      bus_rstart();
      write_byte({ADDR, 1'b1}, a); check({req, " addr+R ack"}, {7'd0, a}, 8'h00);
      read_byte(1'b1, 1'b0, 8'h00, d); check(req, d, exp);
      bus_stop();
   endtask

   task automatic t_reset();
      check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
      check("R1 out_port", out_port, 8'hFF);
      check("R1 cfg", cfg, 8'hFF);
      port_in = 8'hA5;
      read_direct(8'hA5, "R1 default cmd selects input");
   endtask

   task automatic t_wrong_addr();
      logic a;
      bus_start();
      write_byte({7'h39, 1'b0}, a); check("R2 mismatch no ack", {7'd0, a}, 8'h01);
      write_byte(8'h00, a);         check("R2 silent after mismatch", {7'd0, a}, 8'h01);
      bus_stop();
   endtask

   task automatic t_write_regs();
      logic a;
      set_cmd(8'h01, "R3");
      write_byte(8'h96, a); check("R11 data ack", {7'd0, a}, 8'h00);
      write_byte(8'h69, a); check("R11 data ack 2", {7'd0, a}, 8'h00);
      bus_stop();
      check("R11 same reg last byte", out_port, 8'h69);
      check("R11 cfg untouched", cfg, 8'hFF);
   endtask

   task automatic t_select();
      combined_read(8'h03, 8'hFF, "R4 config read");
      combined_read(8'h06, 8'h00, "R5 upper bits ignored polarity");
      combined_read(8'hFD, 8'h69, "R5 sel 1 output");
   endtask

   task automatic t_multi();
      logic a; logic [7:0] d;
      set_cmd(8'h01, "R6");
      bus_rstart();
      write_byte({ADDR, 1'b1}, a); check("R6 addr+R ack", {7'd0, a}, 8'h00);
      for (int k = 0; k < 3; k++) begin
         read_byte(k == 2, 1'b0, 8'h00, d);
         check("R6 repeated byte", d, 8'h69);
      end
      bus_stop();
      read_direct(8'h69, "R7 command kept");
   endtask

   task automatic t_polarity();
      logic a; logic [7:0] d, d2;
      set_cmd(8'h02, "R8");
      write_byte(8'h0F, a); check("R8 pol write ack", {7'd0, a}, 8'h00);
      bus_stop();
      set_cmd(8'h00, "R8");
      bus_stop();
      port_in = 8'h3C;
      read_direct(8'h33, "R8 xor polarity");
      port_in = 8'h5A;
      bus_start();
      write_byte({ADDR, 1'b1}, a); check("R8 addr+R ack", {7'd0, a}, 8'h00);
      read_byte(1'b0, 1'b1, 8'hC3, d);
      read_byte(1'b1, 1'b0, 8'h00, d2);
      bus_stop();
      check("R8 captured at ack", d, 8'h55);
      check("R8 next byte sees change", d2, 8'hCC);
   endtask

   task automatic t_nack();
      logic a; logic [7:0] d;
      port_in = 8'h0F;
      bus_start();
      write_byte({ADDR, 1'b1}, a); check("R9 addr+R ack", {7'd0, a}, 8'h00);
      read_byte(1'b1, 1'b0, 8'h00, d); check("R9 byte before nack", d, 8'h00);
      read_byte(1'b1, 1'b0, 8'h00, d); check("R9 released after nack", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_stop_mid();
      bus_start();
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      check("R10 idle after stop", {7'd0, sda_oe}, 8'h00);
      port_in = 8'hF0;
      read_direct(8'hFF, "R10 next transaction");
   endtask

   task automatic t_input_write();
      logic a;
      set_cmd(8'h00, "R11");
      write_byte(8'h00, a); check("R11 input write ack", {7'd0, a}, 8'h00);
      bus_stop();
      check("R11 out unchanged", out_port, 8'h69);
      check("R11 cfg unchanged", cfg, 8'hFF);
      combined_read(8'h02, 8'h0F, "R11 polarity unchanged");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_wrong_addr();
      t_write_regs();
      t_select();
      t_multi();
      t_polarity();
      t_nack();
      t_stop_mid();
      t_input_write();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule